// File: doc/BRIEF.md
# Serial IQ Sample Deserializer

This block receives complex samples from a serial device port and rebuilds them as parallel I and Q words. The port has a bit clock (the block clock), two data lanes and a frame marker. One sample takes one clock per serial bit. The marker is a single-clock pulse that flags the first bit of a sample. The marker may lag that bit by a programmable number of clocks. The marker's active level is selectable.

Three lane mappings are supported:
- **Dual-lane:** I arrives on lane 0 while Q arrives on lane 1 in the same clocks.
- **Sequential:** all I bits arrive on lane 0, then all Q bits on lane 0.
- **Bit-interleaved:** lane 0 alternates I and Q bits, with each I bit just before the Q bit of the same weight.

Word size per component is set between 4 and 16 bits. The first-sent bit is either the MSB or the LSB, as selected. Upper output bits above the word size are zero.

The block is controlled by a two-state machine with states `ST_HUNT` and `ST_COLLECT`. Its transitions are:
- `T_START`: `ST_HUNT` to `ST_COLLECT` when a marker arrives.
- `T_DONE`: `ST_COLLECT` to `ST_HUNT` when the last bit is taken.
- `T_RESYNC`: `ST_COLLECT` to `ST_COLLECT` when a marker arrives early. This sets the sticky error flag and restarts the sample.

Without a marker, `ST_HUNT` holds and `ST_COLLECT` keeps counting. Mapping, word size and bit order are taken on the marker clock. They stay fixed for the rest of that sample.

Top module: `serial_iq_deser`

## Requirements
- R1: With `cfg_map` = 0 (dual-lane), the bit in slot k on lane 0 is I bit k and on lane 1 is Q bit k. A sample has W slots. The value 3 behaves as 0.
- R2: With `cfg_map` = 1 (sequential), lane 0 carries I bits in slots 0..W-1 and Q bits in slots W..2W-1.
- R3: With `cfg_map` = 2 (bit-interleaved), lane 0 carries I bit k in slot 2k and Q bit k in slot 2k+1.
- R4: The marker counts as active when `frame_in` equals `cfg_frame_pos` (1 = active high, 0 = active low).
- R5: A marker arriving D clocks after slot 0 marks that sample. D is `cfg_frame_dly`, limited to (slots per sample - 1).
- R6: With `cfg_lsb_first` = 0 the first component bit is bit W-1. With `cfg_lsb_first` = 1 it is bit 0.
- R7: W is `cfg_word_size` limited to the range 4..16. Output bits W and above are zero.
- R8: `out_valid` is high for exactly one clock, the clock after the last slot of the sample is taken. `out_i` and `out_q` hold the finished words from that clock until the next sample completes.
- R9: A marker during `ST_COLLECT` sets `frame_err`, which stays set until reset. Assembly restarts with that marker as slot 0.
- R10: Lane bits are ignored until a marker arrives, both after reset and after a completed sample.
- R11: During reset, `out_i`, `out_q`, `out_valid` and `frame_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane0_in | input | 1 | Serial data lane 0 |
| lane1_in | input | 1 | Serial data lane 1 (Q in dual-lane mapping) |
| frame_in | input | 1 | Frame marker |
| cfg_map | input | 2 | Lane mapping: 0 dual-lane, 1 sequential, 2 bit-interleaved, 3 as 0 |
| cfg_frame_pos | input | 1 | Marker active level |
| cfg_frame_dly | input | 5 | Marker lag in clocks |
| cfg_lsb_first | input | 1 | First component bit is the LSB |
| cfg_word_size | input | 5 | Bits per component |
| out_i | output | 16 | Assembled I word |
| out_q | output | 16 | Assembled Q word |
| out_valid | output | 1 | One-clock strobe for a finished sample |
| frame_err | output | 1 | Sticky framing error |

## Verification
The bench builds the block with its default 16-bit maximum word, so a sample spans at most 32 slots and the delay line is 31 clocks deep. It sweeps all three mappings against word sizes 4, 7 and 16, both bit orders, both marker levels, and the delays 0, 1 and slots-1. This covers the shortest and longest samples and the deepest delay tap. Separate runs cover limiting of out-of-range sizes and delays, the reserved mapping code, and idle lanes with no marker. A truncated sample followed by an early marker checks the sticky error and the restart.

// File: rtl/deser_pkg.sv
package deser_pkg;

    typedef enum logic [1:0] {
        MAP_DUAL  = 2'd0,
        MAP_SEQ   = 2'd1,
        MAP_BITIL = 2'd2,
        MAP_RSVD  = 2'd3
    } map_e;

    typedef enum logic {
        ST_HUNT    = 1'b0,
        ST_COLLECT = 1'b1
    } state_e;

endpackage

// File: rtl/deser_align.sv
module deser_align #(
    parameter int DLY_W = 5,
    parameter int NB_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lane0_in,
    input  logic             lane1_in,
    input  logic             frame_in,
    input  logic             cfg_frame_pos,
    input  logic [DLY_W-1:0] cfg_frame_dly,
    input  logic [NB_W-1:0]  nbits,
    output logic             lane0_al,
    output logic             lane1_al,
    output logic             mark
);
    localparam int DEPTH = (1 << DLY_W) - 1;

    logic [DLY_W-1:0] dly_eff;
    logic [1:0]       lane_raw;
    logic [1:0]       lane_al;

    assign lane_raw = {lane1_in, lane0_in};
    assign mark     = (frame_in == cfg_frame_pos);

    always_comb begin
        if ({1'b0, cfg_frame_dly} >= nbits) begin
            dly_eff = DLY_W'(nbits - NB_W'(1));
        end else begin
            dly_eff = cfg_frame_dly;
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [DEPTH-1:0] hist;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist <= '0;
            end else begin
                hist <= {hist[DEPTH-2:0], lane_raw[g]};
            end
        end
        assign lane_al[g] = (dly_eff == '0) ? lane_raw[g]
                                            : hist[dly_eff - DLY_W'(1)];
    end

    assign lane0_al = lane_al[0];
    assign lane1_al = lane_al[1];

    AST_DLY_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, dly_eff} < nbits)); // R5

endmodule

// File: rtl/deser_ctrl.sv
module deser_ctrl
    import deser_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int NB_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark,
    input  logic [NB_W-1:0]  nbits_live,
    output logic             cap_en,
    output logic             first,
    output logic             last,
    output logic [CNT_W-1:0] slot,
    output logic             frame_err
);
    state_e            state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [NB_W-1:0]   nb_q, nb_use;
    logic              err_q, err_n;

    // slot bookkeeping and strobes
    always_comb begin
        first  = mark;
        cap_en = mark || (state_q == ST_COLLECT);
        slot   = mark ? '0 : cnt_q;
        nb_use = mark ? nbits_live : nb_q;
        last   = cap_en && ({1'b0, slot} == (nb_use - NB_W'(1)));
        cnt_n  = slot + CNT_W'(1);
        err_n  = err_q || (mark && (state_q == ST_COLLECT));
    end

    // next state: T_START, T_DONE, T_RESYNC
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (mark) state_n = last ? ST_HUNT : ST_COLLECT;
            end
            ST_COLLECT: begin
                if (last) state_n = ST_HUNT;
                else      state_n = ST_COLLECT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            nb_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= err_n;
            if (cap_en) cnt_q <= cnt_n;
            if (mark)   nb_q  <= nbits_live;
        end
    end

    assign frame_err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R9
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT) |-> ({1'b0, cnt_q} < nb_q)); // R8
    AST_HUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && !mark) |-> !cap_en); // R10

endmodule

// File: rtl/deser_shift.sv
module deser_shift
    import deser_pkg::*;
#(
    parameter int WORD_MAX = 16,
    parameter int SW_W     = 5,
    parameter int CNT_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lane0_al,
    input  logic                lane1_al,
    input  logic                cap_en,
    input  logic                first,
    input  logic                last,
    input  logic [CNT_W-1:0]    slot,
    input  logic [1:0]          cfg_map,
    input  logic                cfg_lsb_first,
    input  logic [SW_W-1:0]     w_live,
    output logic [WORD_MAX-1:0] out_i,
    output logic [WORD_MAX-1:0] out_q,
    output logic                out_valid
);
    localparam int IDX_W = $clog2(WORD_MAX);

    map_e                map_q, map_u;
    logic                lsb_q, lsb_u;
    logic [SW_W-1:0]     w_q, w_u;
    logic [CNT_W-1:0]    w_c, ki, kq, pi_c, pq_c;
    logic                wr_i, wr_q, bi, bq;
    logic [WORD_MAX-1:0] acc_i, acc_q, acc_i_n, acc_q_n;

    always_comb begin
        map_u = first ? map_e'(cfg_map) : map_q;
        lsb_u = first ? cfg_lsb_first   : lsb_q;
        w_u   = first ? w_live          : w_q;
        w_c   = CNT_W'(w_u);
    end

    // route the slot to a component and a bit index
    always_comb begin
        wr_i = 1'b0;
        wr_q = 1'b0;
        bi   = lane0_al;
        bq   = lane0_al;
        ki   = slot;
        kq   = slot;
        case (map_u)
            MAP_SEQ: begin
                if (slot < w_c) begin
                    wr_i = 1'b1;
                end else begin
                    wr_q = 1'b1;
                    kq   = slot - w_c;
                end
            end
            MAP_BITIL: begin
                ki = slot >> 1;
                kq = slot >> 1;
                if (slot[0]) wr_q = 1'b1;
                else         wr_i = 1'b1;
            end
            default: begin
                wr_i = 1'b1;
                wr_q = 1'b1;
                bq   = lane1_al;
            end
        endcase
        pi_c = lsb_u ? ki : (w_c - CNT_W'(1) - ki);
        pq_c = lsb_u ? kq : (w_c - CNT_W'(1) - kq);
    end

    always_comb begin
        acc_i_n = first ? '0 : acc_i;
        acc_q_n = first ? '0 : acc_q;
        if (cap_en && wr_i) acc_i_n[IDX_W'(pi_c)] = bi;
        if (cap_en && wr_q) acc_q_n[IDX_W'(pq_c)] = bq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q     <= MAP_DUAL;
            lsb_q     <= 1'b0;
            w_q       <= '0;
            acc_i     <= '0;
            acc_q     <= '0;
            out_i     <= '0;
            out_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            if (first) begin
                map_q <= map_u;
                lsb_q <= lsb_u;
                w_q   <= w_u;
            end
            if (cap_en) begin
                acc_i <= acc_i_n;
                acc_q <= acc_q_n;
            end
            if (last) begin
                out_i <= acc_i_n;
                out_q <= acc_q_n;
            end
            out_valid <= last;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R8
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (((out_i >> w_q) == '0) && ((out_q >> w_q) == '0))); // R7
    AST_HOLD_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        !last |=> ($stable(out_i) && $stable(out_q))); // R8

endmodule

// File: rtl/serial_iq_deser.sv
module serial_iq_deser
    import deser_pkg::*;
#(
    parameter int WORD_MAX = 16,
    parameter int WORD_MIN = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                lane0_in,
    input  logic                                lane1_in,
    input  logic                                frame_in,
    input  logic [1:0]                          cfg_map,
    input  logic                                cfg_frame_pos,
    input  logic [$clog2(2*WORD_MAX)-1:0]       cfg_frame_dly,
    input  logic                                cfg_lsb_first,
    input  logic [$clog2(WORD_MAX+1)-1:0]       cfg_word_size,
    output logic [WORD_MAX-1:0]                 out_i,
    output logic [WORD_MAX-1:0]                 out_q,
    output logic                                out_valid,
    output logic                                frame_err
);
    localparam int SW_W  = $clog2(WORD_MAX + 1);
    localparam int CNT_W = $clog2(2 * WORD_MAX);
    localparam int NB_W  = CNT_W + 1;
    localparam int DLY_W = CNT_W;

    logic [SW_W-1:0]  w_eff;
    logic [NB_W-1:0]  nbits_live;
    logic             lane0_al, lane1_al, mark;
    logic             cap_en, first, last;
    logic [CNT_W-1:0] slot;

    always_comb begin
        if (cfg_word_size < SW_W'(WORD_MIN))      w_eff = SW_W'(WORD_MIN);
        else if (cfg_word_size > SW_W'(WORD_MAX)) w_eff = SW_W'(WORD_MAX);
        else                                      w_eff = cfg_word_size;
        if (cfg_map == MAP_SEQ || cfg_map == MAP_BITIL)
            nbits_live = NB_W'(w_eff) << 1;
        else
            nbits_live = NB_W'(w_eff);
    end

    deser_align #(.DLY_W(DLY_W), .NB_W(NB_W)) align_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane0_in      (lane0_in),
        .lane1_in      (lane1_in),
        .frame_in      (frame_in),
        .cfg_frame_pos (cfg_frame_pos),
        .cfg_frame_dly (cfg_frame_dly),
        .nbits         (nbits_live),
        .lane0_al      (lane0_al),
        .lane1_al      (lane1_al),
        .mark          (mark)
    );

    deser_ctrl #(.CNT_W(CNT_W), .NB_W(NB_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mark       (mark),
        .nbits_live (nbits_live),
        .cap_en     (cap_en),
        .first      (first),
        .last       (last),
        .slot       (slot),
        .frame_err  (frame_err)
    );

    deser_shift #(.WORD_MAX(WORD_MAX), .SW_W(SW_W), .CNT_W(CNT_W)) shift_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .lane0_al      (lane0_al),
        .lane1_al      (lane1_al),
        .cap_en        (cap_en),
        .first         (first),
        .last          (last),
        .slot          (slot),
        .cfg_map       (cfg_map),
        .cfg_lsb_first (cfg_lsb_first),
        .w_live        (w_eff),
        .out_i         (out_i),
        .out_q         (out_q),
        .out_valid     (out_valid)
    );

endmodule

// File: tb/serial_iq_deser_tb_top.sv
module serial_iq_deser_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lane0_in, lane1_in, frame_in;
    logic [1:0]  cfg_map;
    logic        cfg_frame_pos, cfg_lsb_first;
    logic [4:0]  cfg_frame_dly, cfg_word_size;
    logic [15:0] out_i, out_q;
    logic        out_valid, frame_err;

    int n_run  = 0;
    int n_fail = 0;
    logic exp_err = 1'b0;

    always #10 clk = ~clk;

    serial_iq_deser dut_i (
        .clk(clk), .rst_n(rst_n), .lane0_in(lane0_in), .lane1_in(lane1_in),
        .frame_in(frame_in), .cfg_map(cfg_map), .cfg_frame_pos(cfg_frame_pos),
        .cfg_frame_dly(cfg_frame_dly), .cfg_lsb_first(cfg_lsb_first),
        .cfg_word_size(cfg_word_size), .out_i(out_i), .out_q(out_q),
        .out_valid(out_valid), .frame_err(frame_err)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mask(input int w);
        return 16'((32'd1 << w) - 32'd1);
    endfunction

    function automatic logic bitof(input logic [15:0] v, input int w,
                                   input int k, input bit lsb);
        return lsb ? v[k] : v[w-1-k];
    endfunction

    task automatic run_sample(input int map, input int cfgw, input int w,
                              input bit lsb, input bit pos, input int cfgdly,
                              input int dly, input int pre, input int seed,
                              input string tag);
        int n, vcnt, vcyc;
        logic [15:0] vi, vq, gi, gq;
        n  = (map == 1 || map == 2) ? 2*w : w;
        vi = 16'(seed*40503 + 4660) & mask(w);
        vq = 16'(seed*9973 + 43981) & mask(w);
        vcnt = 0; vcyc = -1; gi = '0; gq = '0;
        @(negedge clk);
        cfg_map = 2'(map); cfg_word_size = 5'(cfgw); cfg_lsb_first = lsb;
        cfg_frame_pos = pos; cfg_frame_dly = 5'(cfgdly);
        frame_in = ~pos; lane0_in = 1'b0; lane1_in = 1'b0;
        for (int j = 0; j < pre + n + dly + 3; j++) begin
            int s;
            s = j - pre;
            @(negedge clk);
            frame_in = ~pos;
            if (j < pre) begin
                lane0_in = 1'(j & 1);
                lane1_in = ~1'(j & 1);
                if (j == 0) frame_in = pos;
            end else if (s < n) begin
                if (map == 1) begin
                    lane0_in = (s < w) ? bitof(vi, w, s, lsb) : bitof(vq, w, s-w, lsb);
                    lane1_in = 1'b0;
                end else if (map == 2) begin
                    lane0_in = (s % 2 == 0) ? bitof(vi, w, s/2, lsb) : bitof(vq, w, s/2, lsb);
                    lane1_in = 1'b0;
                end else begin
                    lane0_in = bitof(vi, w, s, lsb);
                    lane1_in = bitof(vq, w, s, lsb);
                end
            end else begin
                lane0_in = 1'b1;
                lane1_in = 1'b1;
            end
            if (j >= pre && s == dly) frame_in = pos;
            @(posedge clk);
            #5;
            if (out_valid) begin
                vcnt++; vcyc = j; gi = out_i; gq = out_q;
            end
        end
        if (pre > 0) exp_err = 1'b1;
        chk("R8", vcnt, 1, "valid pulse count");
        chk((dly > 0) ? "R5" : "R8", vcyc, pre + dly + n - 1, "valid cycle");
        chk({tag, "+R4+R6+R7"}, gi, vi, "I word");
        chk({tag, "+R4+R6+R7"}, gq, vq, "Q word");
        chk("R9", frame_err, exp_err, "error flag");
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int seed, vc;
        int wl[3] = '{4, 7, 16};
        rst_n = 1'b0; lane0_in = 1'b0; lane1_in = 1'b0; frame_in = 1'b0;
        cfg_map = 2'd0; cfg_frame_pos = 1'b1; cfg_frame_dly = '0;
        cfg_lsb_first = 1'b0; cfg_word_size = 5'd16;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", out_valid, 0, "valid in reset");
        chk("R11", frame_err, 0, "error in reset");
        chk("R11", out_i, 0, "I in reset");
        chk("R11", out_q, 0, "Q in reset");
        rst_n = 1'b1;
        // R10 bits without a marker are dropped
        vc = 0;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            lane0_in = 1'(j & 1); lane1_in = 1'((j >> 1) & 1); frame_in = 1'b0;
            @(posedge clk); #5;
            if (out_valid) vc++;
        end
        chk("R10", vc, 0, "valid without marker");
        chk("R10", out_i, 0, "I without marker");
        seed = 1;
        for (int m = 0; m < 3; m++) begin
            foreach (wl[wi]) begin
                for (int l = 0; l < 2; l++) begin
                    for (int p = 0; p < 2; p++) begin
                        for (int d = 0; d < 3; d++) begin
                            int w, n, dl;
                            w  = wl[wi];
                            n  = (m == 0) ? w : 2*w;
                            dl = (d == 0) ? 0 : (d == 1) ? 1 : n - 1;
                            run_sample(m, w, w, l[0], p[0], dl, dl, 0, seed,
                                       (m == 0) ? "R1" : (m == 1) ? "R2" : "R3");
                            seed++;
                        end
                    end
                end
            end
        end
        run_sample(3, 8, 8, 1'b0, 1'b1, 0, 0, 0, 901, "R1");
        run_sample(0, 2, 4, 1'b1, 1'b1, 0, 0, 0, 902, "R7");
        run_sample(1, 0, 4, 1'b0, 1'b0, 0, 0, 0, 903, "R7");
        run_sample(2, 20, 16, 1'b1, 1'b1, 0, 0, 0, 904, "R7");
        run_sample(0, 4, 4, 1'b0, 1'b1, 20, 3, 0, 905, "R5");
        run_sample(1, 4, 4, 1'b1, 1'b0, 30, 7, 0, 906, "R5");
        // R9 truncated sample then early marker
        run_sample(0, 4, 4, 1'b0, 1'b1, 0, 0, 2, 907, "R9");
        run_sample(2, 5, 5, 1'b1, 1'b1, 0, 0, 3, 908, "R9");
        run_sample(1, 6, 6, 1'b0, 1'b0, 2, 2, 0, 909, "R9");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule